// File: doc/BRIEF.md
# Shifted-Register Invert Execution Unit

This block decodes and executes the integer "move inverted" operation of a processor core. It works in three instruction formats: a 32-bit fixed-width word, a 16-bit compact word and a 32-bit wide compact word. The source operand first goes through a barrel shifter, and the shift type and amount come from immediate fields. The destination receives the bitwise complement of the shifted value. The shifter's carry-out can be written into the carry flag, and the negative and zero flags are taken from the result.

The surrounding pipeline applies a word, a format select and the inside-conditional-block flag. It reads the register named on `src_idx`, which is combinational, and returns that value on `src_val` in the same cycle, together with the current carry flag. One cycle later the unit presents the destination index, the result and a set of mutually exclusive write requests: an ordinary register write, a program-counter write, or an exception return. It also reports a word that is invalid or unpredictable. Register storage, condition evaluation and the exception-return machinery stay outside the block.

Top module: `shinv_exec`

## Requirements
- R1: Shift type code 00 is a logical left shift by the 5-bit amount n. With n = 0 the value passes unchanged and carry-out equals `c_in`. For n > 0 carry-out is source bit 32-n. The result is the complement of the shifted value.
- R2: Type code 01 is a logical right shift. An amount field of 0 means a shift of 32, which gives zero with carry-out equal to source bit 31. Otherwise carry-out is the last bit shifted out.
- R3: Type code 10 is an arithmetic right shift. An amount field of 0 means 32, which gives 32 copies of bit 31 with carry-out equal to bit 31.
- R4: Type code 11 with a nonzero amount is a rotate right, and carry-out is bit 31 of the rotated value. With amount 0 the value becomes {c_in, src[31:1]} and carry-out is src[0].
- R5: When flag setting applies, `flag_we` is 1. `flag_n` is then result bit 31, `flag_z` is 1 exactly when the result is zero, and `flag_c` is the shifter carry-out. There is no overflow-flag output.
- R6: Fixed format (fmt 0): condition bits 31:28, bits 27:21 must be 0001111, S bit 20, bits 19:16 must be zero, Rd bits 15:12, amount bits 11:7, type bits 6:5, bit 4 must be 0, Rm bits 3:0. The word is flagged `out_bad` and raises no write request if the condition is 1111, if bits 27:21 or bit 4 mismatch, if bits 19:16 are nonzero, or if fmt is 3.
- R7: Compact format (fmt 1): bits 15:6 must be 0100001111, Rm is in bits 5:3 and Rd in bits 2:0. The shift is a logical left by 0, and flags are written only when `in_cond_blk` is 0. A mismatch in bits 15:6 sets `out_bad`.
- R8: Wide format (fmt 2): bits 31:21 must be 11101010011, S is bit 20, bits 19:16 must be 1111 and bit 15 must be 0. The fields are imm3 in bits 14:12, Rd in 11:8, imm2 in 7:6, type in 5:4 and Rm in 3:0, and the amount is {imm3, imm2}. Rd = 15 or Rm = 15 sets `out_bad` with no write.
- R9: In the fixed format Rd = 15 raises `pc_we` when S = 0 and `exc_ret` when S = 1. In both cases `result` carries the target, and neither `rd_we` nor `flag_we` is set.
- R10: Outputs are registered. A word accepted with `in_valid` produces `out_valid` and its write requests on the next cycle. Without `in_valid`, and under reset, all requests and `out_bad` are 0.
- R11: `src_idx` combinationally shows the Rm field of the selected format, zero-extended for the compact format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word present this cycle |
| insn | input | 32 | Instruction word (compact format in bits 15:0) |
| fmt | input | 2 | 0 fixed, 1 compact, 2 wide compact, 3 reserved |
| in_cond_blk | input | 1 | Instruction sits inside a conditional block |
| src_val | input | 32 | Value of register `src_idx` |
| c_in | input | 1 | Current carry flag |
| src_idx | output | 4 | Source register index (combinational) |
| out_valid | output | 1 | Registered result present |
| out_bad | output | 1 | Word invalid or unpredictable |
| rd_idx | output | 4 | Destination register index |
| result | output | 32 | Complement of shifted source |
| rd_we | output | 1 | Register write request |
| pc_we | output | 1 | Branch: write result to program counter |
| exc_ret | output | 1 | Exception return to result address |
| flag_we | output | 1 | Write N, Z and C |
| flag_n | output | 1 | New negative flag |
| flag_z | output | 1 | New zero flag |
| flag_c | output | 1 | New carry flag |

## Verification
The bench sweeps every shift type against every amount from 0 to 31 in the fixed and wide formats, on two operand patterns with opposite carry inputs. The zero-amount meanings are the traps here. A design that treats a zero field as "no shift" returns the plain complement instead of zero or a sign fill for the right shifts. A design that takes rotate-by-zero as a rotate loses the carry that should enter bit 31 of the extend case. The carry source for a nonzero left shift is easy to get off by one, and that shows up as a wrong `flag_c` at one end of the amount range. The register-15 cases, in-block flag suppression in the compact format, and malformed words check that the exclusive write requests never fire together and never fire for a rejected word.

// File: rtl/shinv_pkg.sv
package shinv_pkg;

    localparam int AMT_W = 5;
    localparam int IDX_W = 4;
    localparam logic [IDX_W-1:0] PC_IDX = 4'd15;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shtype_e;

    typedef enum logic [1:0] {
        FMT_FIXED = 2'd0,
        FMT_C16   = 2'd1,
        FMT_WIDE  = 2'd2,
        FMT_RSVD  = 2'd3
    } fmt_e;

    typedef struct packed {
        logic [IDX_W-1:0] rd;
        logic [IDX_W-1:0] rm;
        logic [AMT_W-1:0] amt;
        shtype_e          ty;
        logic             set_flags;
        logic             illegal;
        logic             unpred;
        logic             pc_dest;
    } dec_t;

endpackage

// File: rtl/shinv_decode.sv
module shinv_decode
    import shinv_pkg::*;
(
    input  logic [31:0] insn,
    input  logic [1:0]  fmt,
    input  logic        in_cond_blk,
    output dec_t        dec
);

    localparam logic [6:0]  FIXED_OPC = 7'b0001111;
    localparam logic [9:0]  C16_OPC   = 10'b0100001111;
    localparam logic [10:0] WIDE_OPC  = 11'b11101010011;

    always_comb begin
        dec    = '0;
        dec.ty = SH_LSL;
        unique case (fmt_e'(fmt))
            FMT_FIXED: begin
                dec.rd        = insn[15:12];
                dec.rm        = insn[3:0];
                dec.amt       = insn[11:7];
                dec.ty        = shtype_e'(insn[6:5]);
                dec.set_flags = insn[20];
                dec.illegal   = (insn[31:28] == 4'hF) || (insn[27:21] != FIXED_OPC) || insn[4];
                dec.unpred    = (insn[19:16] != 4'h0);
                dec.pc_dest   = (insn[15:12] == PC_IDX);
            end
            FMT_C16: begin
                dec.rd        = {1'b0, insn[2:0]};
                dec.rm        = {1'b0, insn[5:3]};
                dec.amt       = '0;
                dec.ty        = SH_LSL;
                dec.set_flags = !in_cond_blk;
                dec.illegal   = (insn[15:6] != C16_OPC);
            end
            FMT_WIDE: begin
                dec.rd        = insn[11:8];
                dec.rm        = insn[3:0];
                dec.amt       = {insn[14:12], insn[7:6]};
                dec.ty        = shtype_e'(insn[5:4]);
                dec.set_flags = insn[20];
                dec.illegal   = (insn[31:21] != WIDE_OPC) || (insn[19:16] != 4'hF) || insn[15];
                dec.unpred    = (insn[11:8] == PC_IDX) || (insn[3:0] == PC_IDX);
            end
            default: begin
                dec.illegal = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/shinv_shifter.sv
module shinv_shifter
    import shinv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]     val,
    input  shtype_e          ty,
    input  logic [AMT_W-1:0] amt,
    input  logic             c_in,
    output logic [W-1:0]     res,
    output logic             c_out
);

    localparam int NW = AMT_W + 1;

    logic [NW-1:0]  n_eff;
    logic [W:0]     ext;
    logic [W:0]     rtmp;
    logic [W:0]     ltmp;
    logic [2*W-1:0] dbl;

    assign n_eff = (amt == '0) ? NW'(W) : {1'b0, amt};
    assign ext   = {val, 1'b0};

    always_comb begin
        rtmp  = '0;
        ltmp  = '0;
        dbl   = '0;
        res   = val;
        c_out = c_in;
        unique case (ty)
            SH_LSL: begin
                if (amt != '0) begin
                    ltmp  = {1'b0, val} << amt;
                    res   = ltmp[W-1:0];
                    c_out = ltmp[W];
                end
            end
            SH_LSR: begin
                rtmp  = ext >> n_eff;
                res   = rtmp[W:1];
                c_out = rtmp[0];
            end
            SH_ASR: begin
                rtmp  = $signed(ext) >>> n_eff;
                res   = rtmp[W:1];
                c_out = rtmp[0];
            end
            SH_ROR: begin
                if (amt == '0) begin
                    res   = {c_in, val[W-1:1]};
                    c_out = val[0];
                end else begin
                    dbl   = {val, val} >> amt;
                    res   = dbl[W-1:0];
                    c_out = dbl[W-1];
                end
            end
            default: begin
                res   = val;
                c_out = c_in;
            end
        endcase
    end

endmodule

// File: rtl/shinv_exec.sv
module shinv_exec
    import shinv_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       insn,
    input  logic [1:0]        fmt,
    input  logic              in_cond_blk,
    input  logic [REG_W-1:0]  src_val,
    input  logic              c_in,
    output logic [3:0]        src_idx,
    output logic              out_valid,
    output logic              out_bad,
    output logic [3:0]        rd_idx,
    output logic [REG_W-1:0]  result,
    output logic              rd_we,
    output logic              pc_we,
    output logic              exc_ret,
    output logic              flag_we,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c
);

    typedef struct packed {
        logic             valid;
        logic             bad;
        logic             rd_we;
        logic             pc_we;
        logic             exc_ret;
        logic             flag_we;
        logic             n;
        logic             z;
        logic             c;
        logic [IDX_W-1:0] rd;
        logic [REG_W-1:0] res;
    } stage_t;

    dec_t             dec;
    logic [REG_W-1:0] shifted;
    logic             sh_c;
    stage_t           st_d, st_q;

    shinv_decode u_dec (
        .insn        (insn),
        .fmt         (fmt),
        .in_cond_blk (in_cond_blk),
        .dec         (dec)
    );

    shinv_shifter #(.W(REG_W)) u_shf (
        .val   (src_val),
        .ty    (dec.ty),
        .amt   (dec.amt),
        .c_in  (c_in),
        .res   (shifted),
        .c_out (sh_c)
    );

    assign src_idx = dec.rm;

    always_comb begin
        logic reject;
        logic go;
        reject       = dec.illegal || dec.unpred;
        go           = in_valid && !reject;
        st_d         = '0;
        st_d.valid   = in_valid;
        st_d.bad     = in_valid && reject;
        st_d.rd_we   = go && !dec.pc_dest;
        st_d.pc_we   = go && dec.pc_dest && !dec.set_flags;
        st_d.exc_ret = go && dec.pc_dest && dec.set_flags;
        st_d.flag_we = go && dec.set_flags && !dec.pc_dest;
        st_d.res     = ~shifted;
        st_d.n       = st_d.res[REG_W-1];
        st_d.z       = (st_d.res == '0);
        st_d.c       = sh_c;
        st_d.rd      = dec.rd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_bad   = st_q.bad;
    assign rd_idx    = st_q.rd;
    assign result    = st_q.res;
    assign rd_we     = st_q.rd_we;
    assign pc_we     = st_q.pc_we;
    assign exc_ret   = st_q.exc_ret;
    assign flag_we   = st_q.flag_we;
    assign flag_n    = st_q.n;
    assign flag_z    = st_q.z;
    assign flag_c    = st_q.c;

    p_one_dest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_we, pc_we, exc_ret}));

    p_pc_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we || exc_ret) |-> (rd_idx == PC_IDX) && !flag_we);

    p_bad_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_bad |-> !(rd_we || pc_we || exc_ret || flag_we));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(rd_we || pc_we || exc_ret || flag_we || out_bad));

    p_accept_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_zero_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> (flag_z == (result == '0)));

    p_neg_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> (flag_n == result[REG_W-1]));

endmodule

// File: tb/shinv_exec_tb_top.sv
`timescale 1ns/1ps
module shinv_exec_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] insn = '0;
    logic [1:0]  fmt = '0;
    logic        in_cond_blk = 1'b0;
    logic [31:0] src_val = '0;
    logic        c_in = 1'b0;
    logic [3:0]  src_idx;
    logic        out_valid, out_bad, rd_we, pc_we, exc_ret, flag_we;
    logic        flag_n, flag_z, flag_c;
    logic [3:0]  rd_idx;
    logic [31:0] result;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    shinv_exec dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn), .fmt(fmt),
        .in_cond_blk(in_cond_blk), .src_val(src_val), .c_in(c_in),
        .src_idx(src_idx), .out_valid(out_valid), .out_bad(out_bad),
        .rd_idx(rd_idx), .result(result), .rd_we(rd_we), .pc_we(pc_we),
        .exc_ret(exc_ret), .flag_we(flag_we), .flag_n(flag_n),
        .flag_z(flag_z), .flag_c(flag_c)
    );

    // Behavioural shifter: bit-serial, one position per step.
    task automatic ref_shift(input logic [31:0] v, input logic [1:0] ty, input logic [4:0] amt,
                             input logic ci, output logic [31:0] r, output logic co);
        int n;
        r  = v;
        co = ci;
        n  = (amt == 0 && (ty == 2'b01 || ty == 2'b10)) ? 32 : int'(amt);
        if (ty == 2'b11 && amt == 0) begin
            co = v[0];
            r  = {ci, v[31:1]};
        end else begin
            for (int i = 0; i < n; i++) begin
                case (ty)
                    2'b00: begin co = r[31]; r = {r[30:0], 1'b0}; end
                    2'b01: begin co = r[0];  r = {1'b0, r[31:1]}; end
                    2'b10: begin co = r[0];  r = {r[31], r[31:1]}; end
                    default: begin co = r[0]; r = {r[0], r[31:1]}; end
                endcase
            end
        end
    endtask

    function automatic logic [31:0] enc_fixed(input logic [3:0] cond, input logic s, input logic [3:0] rd,
                                              input logic [4:0] amt, input logic [1:0] ty, input logic [3:0] rm);
        return {cond, 7'b0001111, s, 4'h0, rd, amt, ty, 1'b0, rm};
    endfunction

    function automatic logic [31:0] enc_c16(input logic [2:0] rm, input logic [2:0] rd);
        return {16'h0, 10'b0100001111, rm, rd};
    endfunction

    function automatic logic [31:0] enc_wide(input logic s, input logic [3:0] rd, input logic [4:0] amt,
                                             input logic [1:0] ty, input logic [3:0] rm);
        return {11'b11101010011, s, 4'hF, 1'b0, amt[4:2], rd, amt[1:0], ty, rm};
    endfunction

    task automatic note(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one word at a falling edge, sample one cycle later at the next falling edge.
    task automatic run_op(input logic [31:0] w, input logic [1:0] f, input logic cb,
                          input logic [31:0] src, input logic ci, input logic [3:0] exp_rm,
                          input bit e_bad, input bit e_rdwe, input bit e_pcwe, input bit e_exc,
                          input bit e_fwe, input logic [3:0] e_rd, input logic [31:0] e_res,
                          input logic e_c, input string tag);
        logic [5:0] act_ctl, exp_ctl;
        bit ok;
        insn = w; fmt = f; in_cond_blk = cb; src_val = src; c_in = ci; in_valid = 1'b1;
        #1;
        // R11: source index visible before the edge
        note(src_idx == exp_rm, {tag, " R11 src_idx"}, 64'(src_idx), 64'(exp_rm));
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        act_ctl = {out_valid, out_bad, rd_we, pc_we, exc_ret, flag_we};
        exp_ctl = {1'b1, e_bad, e_rdwe, e_pcwe, e_exc, e_fwe};
        ok = (act_ctl == exp_ctl);
        note(ok, {tag, " R10 controls"}, 64'(act_ctl), 64'(exp_ctl));
        if (!e_bad) begin
            note(rd_idx == e_rd && result == e_res, {tag, " result"},
                 {28'h0, rd_idx, result}, {28'h0, e_rd, e_res});
        end
        if (e_fwe) begin
            note({flag_n, flag_z, flag_c} == {e_res[31], e_res == 0, e_c}, {tag, " R5 flags"},
                 64'({flag_n, flag_z, flag_c}), 64'({e_res[31], e_res == 32'h0, e_c}));
        end
    endtask

    function automatic string ty_tag(input logic [1:0] ty);
        case (ty)
            2'b00: return "R1 lsl";
            2'b01: return "R2 lsr";
            2'b10: return "R3 asr";
            default: return "R4 ror";
        endcase
    endfunction

    task automatic t_reset();
        note({out_valid, out_bad, rd_we, pc_we, exc_ret, flag_we} == 6'b0, "R10 reset state",
             64'({out_valid, out_bad, rd_we, pc_we, exc_ret, flag_we}), 64'h0);
    endtask

    // R1 R2 R3 R4 R5 R6: fixed-format sweep of every type and amount.
    task automatic t_fixed_sweep();
        logic [31:0] pats [2];
        logic [31:0] r;
        logic co;
        pats[0] = 32'h8F3C_0A51;
        pats[1] = 32'h7E01_C3A4;
        for (int p = 0; p < 2; p++) begin
            for (int t = 0; t < 4; t++) begin
                for (int a = 0; a < 32; a++) begin
                    logic ci;
                    ci = (p == 0);
                    ref_shift(pats[p], 2'(t), 5'(a), ci, r, co);
                    run_op(enc_fixed(4'hE, 1'b1, 4'd3, 5'(a), 2'(t), 4'd9), 2'd0, 1'b0, pats[p], ci,
                           4'd9, 0, 1, 0, 0, 1, 4'd3, ~r, co, {ty_tag(2'(t)), " R6 fixed"});
                end
            end
        end
        // result becomes zero: complement of all ones
        run_op(enc_fixed(4'h0, 1'b1, 4'd1, 5'd0, 2'b00, 4'd2), 2'd0, 1'b0, 32'hFFFF_FFFF, 1'b1,
               4'd2, 0, 1, 0, 0, 1, 4'd1, 32'h0, 1'b1, "R5 zero result");
        // S = 0: no flag write
        run_op(enc_fixed(4'h1, 1'b0, 4'd7, 5'd4, 2'b01, 4'd5), 2'd0, 1'b0, 32'h1234_5678, 1'b0,
               4'd5, 0, 1, 0, 0, 0, 4'd7, ~32'h0123_4567, 1'b0, "R5 no flags S0");
    endtask

    // R7: compact format, flags only outside a conditional block.
    task automatic t_c16();
        for (int k = 0; k < 8; k++) begin
            logic cb;
            logic [31:0] v;
            cb = k[0];
            v  = 32'hA5A5_0000 ^ (32'h1111_1111 * k);
            run_op(enc_c16(3'(k), 3'(7 - k)), 2'd1, cb, v, k[1], 4'(k),
                   0, 1, 0, 0, !cb, 4'(7 - k), ~v, k[1], "R7 compact");
        end
    endtask

    // R8: wide format amount {imm3,imm2}; register 15 rejected.
    task automatic t_wide();
        logic [31:0] r;
        logic co;
        logic [31:0] v;
        v = 32'hC001_D00D;
        for (int t = 0; t < 4; t++) begin
            for (int a = 0; a < 32; a++) begin
                ref_shift(v, 2'(t), 5'(a), a[0], r, co);
                run_op(enc_wide(a[1], 4'd12, 5'(a), 2'(t), 4'd4), 2'd2, 1'b0, v, a[0], 4'd4,
                       0, 1, 0, 0, a[1], 4'd12, ~r, co, {ty_tag(2'(t)), " R8 wide"});
            end
        end
        run_op(enc_wide(1'b0, 4'd15, 5'd3, 2'b00, 4'd4), 2'd2, 1'b0, v, 1'b0, 4'd4,
               1, 0, 0, 0, 0, 4'd0, 32'h0, 1'b0, "R8 wide rd15");
        run_op(enc_wide(1'b1, 4'd2, 5'd3, 2'b00, 4'd15), 2'd2, 1'b0, v, 1'b0, 4'd15,
               1, 0, 0, 0, 0, 4'd0, 32'h0, 1'b0, "R8 wide rm15");
    endtask

    // R9: fixed format destination 15.
    task automatic t_pc_dest();
        run_op(enc_fixed(4'hE, 1'b0, 4'd15, 5'd0, 2'b00, 4'd15), 2'd0, 1'b0, 32'hFFFF_F000, 1'b0,
               4'd15, 0, 0, 1, 0, 0, 4'd15, 32'h0000_0FFF, 1'b0, "R9 branch");
        run_op(enc_fixed(4'hE, 1'b1, 4'd15, 5'd8, 2'b00, 4'd1), 2'd0, 1'b0, 32'hFFFF_FF00, 1'b1,
               4'd1, 0, 0, 0, 1, 0, 4'd15, 32'h0000_FFFF, 1'b0, "R9 exception return");
    endtask

    // R6 R7 R8: malformed words are flagged and silent.
    task automatic t_invalid();
        logic [31:0] w;
        run_op(enc_fixed(4'hF, 1'b1, 4'd3, 5'd1, 2'b00, 4'd2), 2'd0, 1'b0, 32'h5, 1'b0, 4'd2,
               1, 0, 0, 0, 0, 4'd0, 32'h0, 1'b0, "R6 cond 1111");
        w = enc_fixed(4'hE, 1'b1, 4'd3, 5'd1, 2'b00, 4'd2) | 32'h10;
        run_op(w, 2'd0, 1'b0, 32'h5, 1'b0, 4'd2, 1, 0, 0, 0, 0, 4'd0, 32'h0, 1'b0, "R6 bit4 set");
        w = enc_fixed(4'hE, 1'b0, 4'd3, 5'd1, 2'b00, 4'd2) | 32'h0004_0000;
        run_op(w, 2'd0, 1'b0, 32'h5, 1'b0, 4'd2, 1, 0, 0, 0, 0, 4'd0, 32'h0, 1'b0, "R6 bits19:16");
        w = enc_fixed(4'hE, 1'b0, 4'd3, 5'd1, 2'b00, 4'd2) ^ 32'h0020_0000;
        run_op(w, 2'd0, 1'b0, 32'h5, 1'b0, 4'd2, 1, 0, 0, 0, 0, 4'd0, 32'h0, 1'b0, "R6 opcode");
        run_op(enc_fixed(4'hE, 1'b0, 4'd3, 5'd1, 2'b00, 4'd2), 2'd3, 1'b0, 32'h5, 1'b0, 4'd0,
               1, 0, 0, 0, 0, 4'd0, 32'h0, 1'b0, "R6 fmt3");
        w = enc_c16(3'd1, 3'd2) ^ 32'h0000_0040;
        run_op(w, 2'd1, 1'b0, 32'h5, 1'b0, 4'd1, 1, 0, 0, 0, 0, 4'd0, 32'h0, 1'b0, "R7 bad opcode");
        w = enc_wide(1'b0, 4'd2, 5'd1, 2'b00, 4'd3) | 32'h0000_8000;
        run_op(w, 2'd2, 1'b0, 32'h5, 1'b0, 4'd3, 1, 0, 0, 0, 0, 4'd0, 32'h0, 1'b0, "R8 bit15 set");
    endtask

    // R10: no request without in_valid.
    task automatic t_idle();
        insn = enc_fixed(4'hE, 1'b1, 4'd3, 5'd1, 2'b00, 4'd2);
        fmt = 2'd0;
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        note({out_valid, out_bad, rd_we, pc_we, exc_ret, flag_we} == 6'b0, "R10 idle",
             64'({out_valid, out_bad, rd_we, pc_we, exc_ret, flag_we}), 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_idle();
        t_fixed_sweep();
        t_c16();
        t_wide();
        t_pc_dest();
        t_invalid();
        t_idle();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule